// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block chooses one winner among sixteen interrupt request lines of a 16-bit microcontroller and presents the word address of that winner's vector. Line 15 is the reset class, lines 14 and 13 are the non-maskable class, and lines 12 down to 0 are maskable. A higher line number always beats a lower one. The winner is picked combinationally each cycle and registered, so the pending strobe and vector address appear one clock after a request is seen.

The same block also guards instruction fetches. A fetch into the low peripheral-register window, or into any address that lies outside the configured memory regions, raises a reset request. At boot it inspects the reset-vector word: if that word is all ones, meaning the vector was never programmed, it asks for the deepest sleep mode and keeps asking until the next reset. While the CPU acknowledges, the vector output is frozen. For vectors driven by a single flag, a one-cycle clear pulse goes back to that flag.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When `irq_pend` is 1, `vec_addr` equals 16'hFFE0 + 2 × (winning line index). The winner is the highest-numbered active line. When `irq_pend` is 0, `vec_addr` is 16'h0000.
- R2: Line 15 is active whenever its request is high, whatever `irq_en` and `gie` hold, so it beats every other request (vector 16'hFFFE).
- R3: Lines 14 and 13 are active only when both the request and `irq_en` are high. `gie` has no effect on them.
- R4: Lines 12 down to 0 are active only when the request, `irq_en` and `gie` are all high.
- R5: With `irq_ack` low, `irq_pend` and `vec_addr` show the arbitration result of the inputs seen at the previous rising clock edge.
- R6: While `irq_ack` is high at a clock edge, `irq_pend` and `vec_addr` keep their values across that edge.
- R7: While `irq_ack` and `irq_pend` are both high, `irq_clr` has exactly bit *k* set, where *k* is the current vector index, unless line *k* is shared. The shared lines by default are 15, 14, 13, 10, 3, 1 and 0. In every other case `irq_clr` is zero.
- R8: A fetch (`fetch_vld` high) from 16'h0000 to 16'h01FF sets `rst_req` one clock later.
- R9: A fetch outside every mapped region sets `rst_req` one clock later. The default regions are 16'h0200–16'h03FF and 16'hE000–16'hFFFF. A fetch inside a region, or no fetch at all, leaves `rst_req` low.
- R10: On the first active clock after reset, `lpm_req` takes the value (`rv_word` == 16'hFFFF) and then holds it until the next reset. Later changes of `rv_word` have no effect.
- R11: While reset is held, and before the first active clock, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 16 | Request lines, one per vector; shared flags are ORed upstream |
| irq_en | input | 16 | Per-line enables |
| gie | input | 1 | Global enable for the maskable class |
| fetch_vld | input | 1 | An instruction fetch is in progress |
| fetch_addr | input | 16 | Fetch byte address |
| rv_word | input | 16 | Content of the reset-vector word |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_pend | output | 1 | Registered interrupt-pending strobe |
| vec_addr | output | 16 | Vector word address of the winner |
| irq_clr | output | 16 | One-hot clear pulse for single-flag vectors |
| rst_req | output | 1 | Reset request from an illegal fetch |
| lpm_req | output | 1 | Deep-sleep request for an unprogrammed reset vector |

## Verification
A wrong winner index shows at `vec_addr` on the very next clock as an address off by a multiple of two. A lost pending bit shows as `irq_pend` low while an enabled request stands. A hold that fails during acknowledge moves `vec_addr` one edge into the ack, and a wrong shared mask shows at once as a stray or missing `irq_clr` bit. Fetch-guard and boot-capture errors surface one clock after the fetch or after reset release. The per-cycle model therefore catches each of them within a single cycle of its cause.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {CLS_RESET, CLS_NMI, CLS_MASK} irq_cls_e;

  // top line is reset class, next two non-maskable, rest maskable
  function automatic irq_cls_e cls_of(input int idx, input int n);
    if (idx == n - 1)      return CLS_RESET;
    else if (idx >= n - 3) return CLS_NMI;
    else                   return CLS_MASK;
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  en,
  input  logic          gie,
  output logic [N-1:0]  act,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);
  for (genvar i = 0; i < N; i++) begin : g_mask
    always_comb begin
      unique case (cls_of(i, N))
        CLS_RESET: act[i] = req[i];
        CLS_NMI:   act[i] = req[i] & en[i];
        default:   act[i] = req[i] & en[i] & gie;
      endcase
    end
  end

  // later (higher) index overrides: highest active line wins
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i]) begin
        win_vld = 1'b1;
        win_idx = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int          AW      = 16,
  parameter int          N_REG   = 2,
  parameter logic [AW-1:0] SFR_TOP = 16'h01FF,
  parameter logic [N_REG*AW-1:0] REG_LO = {16'hE000, 16'h0200},
  parameter logic [N_REG*AW-1:0] REG_HI = {16'hFFFF, 16'h03FF}
) (
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  output logic          bad_fetch
);
  logic [N_REG-1:0] hit;

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    assign hit[r] = (fetch_addr >= REG_LO[r*AW +: AW]) &&
                    (fetch_addr <= REG_HI[r*AW +: AW]);
  end

  assign bad_fetch = fetch_vld && ((fetch_addr <= SFR_TOP) || (hit == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          N        = 16,
  parameter int          AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFE0,
  parameter logic [N-1:0]  SHARED   = 16'hE40B,
  parameter logic [AW-1:0] UNPROG   = 16'hFFFF,
  parameter int          N_REG    = 2,
  parameter logic [AW-1:0] SFR_TOP  = 16'h01FF,
  parameter logic [N_REG*AW-1:0] REG_LO = {16'hE000, 16'h0200},
  parameter logic [N_REG*AW-1:0] REG_HI = {16'hFFFF, 16'h03FF}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic [N-1:0]  irq_en,
  input  logic          gie,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] rv_word,
  input  logic          irq_ack,
  output logic          irq_pend,
  output logic [AW-1:0] vec_addr,
  output logic [N-1:0]  irq_clr,
  output logic          rst_req,
  output logic          lpm_req
);
  localparam int IW = $clog2(N);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [N-1:0]  act;
  logic          win_vld;
  logic [IW-1:0] win_idx;
  logic          bad_fetch;

  irq_arbiter #(.N(N), .IW(IW)) u_arb (
    .req(irq_req), .en(irq_en), .gie(gie),
    .act(act), .win_vld(win_vld), .win_idx(win_idx)
  );

  fetch_guard #(.AW(AW), .N_REG(N_REG), .SFR_TOP(SFR_TOP),
                .REG_LO(REG_LO), .REG_HI(REG_HI)) u_guard (
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .bad_fetch(bad_fetch)
  );

  logic          pend_q, pend_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          rst_q, rst_d;
  logic          boot_q, boot_d;
  logic          lpm_q, lpm_d;
  logic          sel_en;

  // next state
  always_comb begin
    sel_en = !irq_ack;
    pend_d = pend_q;
    idx_d  = idx_q;
    if (sel_en) begin
      pend_d = win_vld;
      idx_d  = win_idx;
    end
    rst_d  = bad_fetch;
    boot_d = 1'b1;
    lpm_d  = boot_q ? lpm_q : (rv_word == UNPROG);
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      rst_q  <= 1'b0;
      boot_q <= 1'b0;
      lpm_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
      rst_q  <= rst_d;
      boot_q <= boot_d;
      lpm_q  <= lpm_d;
    end
  end

  assign irq_pend = pend_q;
  assign vec_addr = pend_q ? (VEC_BASE + AW'({idx_q, 1'b0})) : '0;
  assign rst_req  = rst_q;
  assign lpm_req  = lpm_q;

  always_comb begin
    irq_clr = '0;
    if (irq_ack && pend_q && !SHARED[idx_q]) irq_clr[idx_q] = 1'b1;
  end

  // assertions
  assert_win_highest_R1: assert property (@(posedge clk) disable iff (!rst_i)
    win_vld |-> (act[win_idx] && ((act >> win_idx) == N'(1))));
  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (!irq_ack && irq_req[N-1]) |=> (irq_pend && vec_addr == VEC_BASE + AW'(2*(N-1))));
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    irq_ack |=> ($stable(vec_addr) && $stable(irq_pend)));
  assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(irq_clr) && ((irq_clr == '0) || (irq_ack && irq_pend)));
  assert_sfr_fetch_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (fetch_vld && fetch_addr <= SFR_TOP) |=> rst_req);
  assert_lpm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_i)
    lpm_req |=> lpm_req);
endmodule

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_req, irq_en, fetch_addr, rv_word;
  logic        gie, fetch_vld, irq_ack;
  logic        irq_pend, rst_req, lpm_req;
  logic [15:0] vec_addr, irq_clr;

  irq_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .gie(gie),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .rv_word(rv_word),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .vec_addr(vec_addr),
    .irq_clr(irq_clr), .rst_req(rst_req), .lpm_req(lpm_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  localparam logic [15:0] SHARED_SET = 16'hE40B;

  // behavioural reference
  int  rel;
  bit  m_pend, m_rst, m_lpm, m_boot;
  int  m_idx;

  function automatic bit line_active(int i);
    if (i == 15) return irq_req[i];
    if (i >= 13) return irq_req[i] && irq_en[i];
    return irq_req[i] && irq_en[i] && gie;
  endfunction

  function automatic bit illegal(logic [15:0] a);
    if (a <= 16'h01FF) return 1;
    if (a >= 16'h0200 && a <= 16'h03FF) return 0;
    if (a >= 16'hE000) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; m_pend = 0; m_idx = 0; m_rst = 0; m_lpm = 0; m_boot = 0;
    end else begin
      if (rel >= 2) begin
        if (!irq_ack) begin
          m_pend = 0; m_idx = 0;
          for (int i = 15; i >= 0; i--)
            if (!m_pend && line_active(i)) begin m_pend = 1; m_idx = i; end
        end
        m_rst = fetch_vld && illegal(fetch_addr);
        if (!m_boot) begin m_boot = 1; m_lpm = (rv_word == 16'hFFFF); end
      end
      if (rel < 3) rel++;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    logic [15:0] e_vec, e_clr;
    e_vec = m_pend ? 16'(16'hFFE0 + 2*m_idx) : 16'h0;
    e_clr = (irq_ack && m_pend && !SHARED_SET[m_idx]) ? 16'(1 << m_idx) : 16'h0;
    check("R5 pend", {15'b0, irq_pend}, {15'b0, m_pend});
    check("R1 vec", vec_addr, e_vec);
    check("R7 clr", irq_clr, e_clr);
    check("R8 rst_req", {15'b0, rst_req}, {15'b0, m_rst});
    check("R10 lpm", {15'b0, lpm_req}, {15'b0, m_lpm});
  endtask

  // one clock; compare a quarter period after the edge, before new drive
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    cmp_all();
  endtask

  task automatic idle_inputs();
    irq_req = 0; irq_en = 0; gie = 0; fetch_vld = 0;
    fetch_addr = 16'hE000; irq_ack = 0;
  endtask

  task automatic do_reset(logic [15:0] rv);
    rst_n = 0; rv_word = rv; idle_inputs();
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R11 reset pend", {15'b0, irq_pend}, 16'h0);
    check("R11 reset vec", vec_addr, 16'h0);
    check("R11 reset clr", irq_clr, 16'h0);
    check("R11 reset rst", {15'b0, rst_req}, 16'h0);
    check("R11 reset lpm", {15'b0, lpm_req}, 16'h0);
    rst_n = 1;
    repeat (4) step();
  endtask

  initial begin
    do_reset(16'hFFFF);
    check("R10 unprogrammed", {15'b0, lpm_req}, 16'h1);
    rv_word = 16'hC000; step(); step();
    check("R10 sticky", {15'b0, lpm_req}, 16'h1);

    do_reset(16'hC000);
    check("R10 programmed", {15'b0, lpm_req}, 16'h0);

    // R4 maskable needs gie
    irq_req[5] = 1; irq_en[5] = 1; gie = 0; step();
    check("R4 gie off", {15'b0, irq_pend}, 16'h0);
    gie = 1; step();
    check("R4 gie on", vec_addr, 16'hFFEA);
    // R3 nmi ignores gie, obeys enable
    irq_req[14] = 1; irq_en[14] = 1; gie = 0; step();
    check("R3 nmi gie off", vec_addr, 16'hFFFC);
    irq_en[14] = 0; step();
    check("R3 nmi disabled", {15'b0, irq_pend}, 16'h0);
    // R2 reset line beats all, no enable
    irq_req = 16'hFFFF; irq_en = 16'hFFFF; gie = 1; irq_en[15] = 0; step();
    check("R2 reset wins", vec_addr, 16'hFFFE);
    // R6/R7 ack hold and clear
    idle_inputs(); irq_req[7] = 1; irq_en[7] = 1; gie = 1; step();
    check("R1 line7", vec_addr, 16'hFFEE);
    irq_ack = 1; irq_req[12] = 1; irq_en[12] = 1; #1;
    check("R7 clear single", irq_clr, 16'h0080);
    step();
    check("R6 hold", vec_addr, 16'hFFEE);
    irq_ack = 0; step();
    check("R5 update", vec_addr, 16'hFFF8);
    idle_inputs(); irq_req[3] = 1; irq_en[3] = 1; gie = 1; step();
    irq_ack = 1; #1;
    check("R7 shared no clear", irq_clr, 16'h0);
    step(); idle_inputs();
    // R8/R9 fetch guard
    fetch_vld = 1; fetch_addr = 16'h0100; step();
    check("R8 sfr fetch", {15'b0, rst_req}, 16'h1);
    fetch_addr = 16'h8000; step();
    check("R9 unmapped", {15'b0, rst_req}, 16'h1);
    fetch_addr = 16'h0300; step();
    check("R9 mapped", {15'b0, rst_req}, 16'h0);
    fetch_vld = 0; fetch_addr = 16'h0000; step();
    check("R9 no fetch", {15'b0, rst_req}, 16'h0);

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      irq_req = 16'($urandom) & 16'($urandom);
      if ($urandom_range(3) != 0) irq_req[15] = 0;
      irq_en = 16'($urandom); gie = 1'($urandom);
      fetch_vld = 1'($urandom); fetch_addr = 16'($urandom);
      irq_ack = ($urandom_range(3) == 0);
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule